// File: doc/BRIEF.md
# Serial CRC Frame Encoder

The block takes a message one bit per clock, cuts every frame into a fixed number of equal subframes, and sends each subframe out unchanged followed by its cyclic redundancy checksum. The output is therefore a bit stream with a valid strobe and a flag that is high on checksum bits. The first bit of a frame is marked with a start-of-frame strobe. Every later bit is counted against the compile-time subframe length and subframe count.

All configuration is fixed at elaboration. This covers the generator polynomial of degree `R`, given as `R+1` coefficients in descending power with a leading one, and the register preset loaded at each subframe start. It also covers the choice between direct division and zero-augmented division, bit reversal of each 8-bit input group before it reaches the register, reversal of the remainder, and the XOR mask applied last. While checksum bits are being sent, the input side drops `in_ready` so that no message bit is lost.

Top module: `crc_frame_enc`

## Requirements
- R1: A message bit accepted in cycle t (in_valid and in_ready high, and either a frame is in progress or in_sof is high) appears on out_bit in cycle t+1 with out_valid high and out_is_crc low. Data bits are sent in arrival order and are never reversed.
- R2: Once the last data bit of a subframe is accepted, exactly R checksum bits follow it on consecutive cycles with out_is_crc high. They are sent from the highest-power stage down to the lowest.
- R3: in_ready is low for exactly the R cycles in which a checksum is being shifted out, and high in every other cycle after reset. As a result, a source that holds in_valid high loses no bit and waits R cycles per subframe boundary within a frame.
- R4: The division register is preset to INIT at the first bit of every subframe, so identical subframes within one frame get identical checksums.
- R5: With DIRECT=0, the checksum is the register content after the subframe bits and then R zero bits have entered the low end of the register. Whenever the top stage was one, the register is XORed with the low R polynomial coefficients. With x^3+x^2+1, a zero preset and subframe 10011, the checksum is 011.
- R6: With DIRECT=1, each message bit is XORed with the top stage to form the feedback, and no zeros are appended. With x^8+x^2+x+1, preset all ones, final mask all ones and the 23-bit message 10011000000000000000011, the checksum is 00011100.
- R7: With REFLECT_IN=1, each group of 8 arriving bits enters the register last-arrived-first. The data bits on the output stay in arrival order.
- R8: With REFLECT_OUT=1, the R-bit remainder is reversed end to end before the final mask. With x^16+x^12+x^5+1, preset and mask 0xFFFF and both reflections on, the ASCII string "123456789" sent byte by byte, most significant bit first, yields checksum 0x906E.
- R9: The checksum is XORed with XOR_OUT before it is sent, and a zero mask leaves it unchanged.
- R10: While no frame is in progress, bits offered without in_sof are dropped and produce no output.
- R11: A synchronous active-high reset clears out_valid, sets in_ready, and returns the counters to the start of a frame, so a half-sent frame is abandoned.
- R12: A frame consists of SUBFRAMES×SUB_LEN input bits and produces SUBFRAMES×(SUB_LEN+R) output bits. After the last checksum, the block waits for a new in_sof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source offers a message bit |
| in_sof | input | 1 | Offered bit is the first of a frame |
| in_bit | input | 1 | Message bit |
| in_ready | output | 1 | Block can take a bit this cycle |
| out_valid | output | 1 | out_bit carries a bit |
| out_bit | output | 1 | Encoded stream bit |
| out_is_crc | output | 1 | Current output bit belongs to a checksum |

## Verification
Two events share a cycle at each subframe boundary. The final checksum bit of one subframe is shifted out in the same cycle that in_ready rises again, and the next bit is accepted then with the register preset at that same edge. The bench provokes this by holding in_valid high across multi-subframe frames. It judges the result by counting stalled cycles, which must equal R per inner boundary, and by comparing the complete output stream bit for bit against the expected data and checksum sequence. A second coincidence is tested by feeding bits without in_sof right after a checksum ends: these must be dropped, while the last checksum bit still appears.

// File: rtl/crc_enc_pkg.sv
package crc_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_EMIT = 2'd2
    } enc_state_e;

    localparam int MAX_DEGREE = 32;

endpackage

// File: rtl/crc_divider.sv
module crc_divider #(
    parameter int           R          = 16,
    parameter logic [R-1:0] TAPS       = 16'h1021,
    parameter logic [R-1:0] INIT       = '0,
    parameter bit           DIRECT     = 1'b0,
    parameter bit           REFLECT_IN = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         feed,
    input  logic         start,
    input  logic         bit_in,
    output logic [R-1:0] rem_out
);

    typedef struct packed {
        logic [R-1:0] lfsr;
        logic [7:0]   acc;
        logic [2:0]   pos;
    } div_state_t;

    div_state_t q, d;

    function automatic logic [R-1:0] step(input logic [R-1:0] s, input logic b);
        logic fb;
        if (DIRECT) begin
            fb = s[R-1] ^ b;
            return {s[R-2:0], 1'b0} ^ (fb ? TAPS : '0);
        end else begin
            return {s[R-2:0], b} ^ (s[R-1] ? TAPS : '0);
        end
    endfunction

    logic [R-1:0] base, nxt, rem;
    logic [2:0]   pos_e;
    logic [7:0]   acc_e, acc_n;

    always_comb begin
        base  = start ? INIT : q.lfsr;
        pos_e = start ? 3'd0 : q.pos;
        acc_e = start ? 8'd0 : q.acc;
        acc_n = acc_e;
        acc_n[pos_e] = bit_in;
        nxt = base;
        if (REFLECT_IN) begin
            if (pos_e == 3'd7) begin
                for (int i = 7; i >= 0; i--) nxt = step(nxt, acc_n[i]);
            end
        end else begin
            nxt = step(base, bit_in);
        end
        rem = nxt;
        if (!DIRECT) begin
            for (int i = 0; i < R; i++) rem = step(rem, 1'b0);
        end
        d = q;
        if (feed) begin
            d.lfsr = nxt;
            d.acc  = acc_n;
            d.pos  = pos_e + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.lfsr <= INIT;
            q.acc  <= '0;
            q.pos  <= '0;
        end else begin
            q <= d;
        end
    end

    assign rem_out = rem;

    // R7
    byte_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (feed && start) |=> (q.pos == 3'd1));

endmodule

// File: rtl/crc_finish.sv
module crc_finish #(
    parameter int           R           = 16,
    parameter bit           REFLECT_OUT = 1'b0,
    parameter logic [R-1:0] XOR_OUT     = '0
) (
    input  logic [R-1:0] rem_in,
    output logic [R-1:0] chk_out
);

    logic [R-1:0] oriented;

    generate
        if (REFLECT_OUT) begin : g_flip
            for (genvar i = 0; i < R; i++) begin : g_bit
                assign oriented[i] = rem_in[R-1-i];
            end
        end else begin : g_keep
            assign oriented = rem_in;
        end
    endgenerate

    assign chk_out = oriented ^ XOR_OUT;

endmodule

// File: rtl/crc_frame_enc.sv
module crc_frame_enc #(
    parameter int           R           = 16,
    parameter logic [R:0]   POLY        = 17'h11021,
    parameter logic [R-1:0] INIT        = '0,
    parameter logic [R-1:0] XOR_OUT     = '0,
    parameter bit           DIRECT      = 1'b0,
    parameter bit           REFLECT_IN  = 1'b0,
    parameter bit           REFLECT_OUT = 1'b0,
    parameter int           SUBFRAMES   = 1,
    parameter int           SUB_LEN     = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    output logic out_is_crc
);
    import crc_enc_pkg::*;

    localparam int BW = $clog2(SUB_LEN + 1);
    localparam int SW = $clog2(SUBFRAMES + 1);
    localparam int CW = $clog2(R + 1);

    generate
        if (POLY[R] != 1'b1) begin : g_bad_poly
            $error("polynomial needs a leading coefficient of one");
        end
        if (REFLECT_IN && (SUB_LEN % 8 != 0)) begin : g_bad_len
            $error("byte reflection needs a subframe length that is a multiple of 8");
        end
        if (R < 2 || R > MAX_DEGREE) begin : g_bad_deg
            $error("degree out of range");
        end
    endgenerate

    typedef struct packed {
        enc_state_e    state;
        logic [BW-1:0] bit_cnt;
        logic [SW-1:0] sub_cnt;
        logic [CW-1:0] crc_cnt;
        logic [R-1:0]  shreg;
        logic          ov;
        logic          ob;
        logic          oc;
    } enc_t;

    enc_t q, d;

    logic         accept, sub_start, sub_last;
    logic [R-1:0] rem, chk;

    crc_divider #(
        .R(R), .TAPS(POLY[R-1:0]), .INIT(INIT),
        .DIRECT(DIRECT), .REFLECT_IN(REFLECT_IN)
    ) u_div (
        .clk(clk), .rst(rst), .feed(accept), .start(sub_start),
        .bit_in(in_bit), .rem_out(rem)
    );

    crc_finish #(
        .R(R), .REFLECT_OUT(REFLECT_OUT), .XOR_OUT(XOR_OUT)
    ) u_fin (
        .rem_in(rem), .chk_out(chk)
    );

    always_comb begin
        in_ready  = (q.state != ST_EMIT);
        accept    = in_valid && in_ready && ((q.state == ST_DATA) || in_sof);
        sub_start = accept && (q.bit_cnt == '0);
        sub_last  = accept && (q.bit_cnt == BW'(SUB_LEN - 1));

        d    = q;
        d.ov = 1'b0;
        d.ob = 1'b0;
        d.oc = 1'b0;
        case (q.state)
            ST_IDLE, ST_DATA: begin
                if (accept) begin
                    d.ov = 1'b1;
                    d.ob = in_bit;
                    if (sub_last) begin
                        d.state   = ST_EMIT;
                        d.bit_cnt = '0;
                        d.crc_cnt = '0;
                        d.shreg   = chk;
                    end else begin
                        d.state   = ST_DATA;
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end
                end
            end
            ST_EMIT: begin
                d.ov    = 1'b1;
                d.oc    = 1'b1;
                d.ob    = q.shreg[R-1];
                d.shreg = {q.shreg[R-2:0], 1'b0};
                if (q.crc_cnt == CW'(R - 1)) begin
                    d.crc_cnt = '0;
                    if (q.sub_cnt == SW'(SUBFRAMES - 1)) begin
                        d.sub_cnt = '0;
                        d.state   = ST_IDLE;
                    end else begin
                        d.sub_cnt = q.sub_cnt + 1'b1;
                        d.state   = ST_DATA;
                    end
                end else begin
                    d.crc_cnt = q.crc_cnt + 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state   <= ST_IDLE;
            q.bit_cnt <= '0;
            q.sub_cnt <= '0;
            q.crc_cnt <= '0;
            q.shreg   <= '0;
            q.ov      <= 1'b0;
            q.ob      <= 1'b0;
            q.oc      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign out_valid  = q.ov;
    assign out_bit    = q.ob;
    assign out_is_crc = q.oc;

    // R1
    data_echo_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && !out_is_crc && (out_bit == $past(in_bit))));

    // R3
    crc_stall_chk: assert property (@(posedge clk) disable iff (rst)
        out_is_crc |-> !$past(in_ready));

    // R2
    crc_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_is_crc |-> out_valid);

    // R10
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (q.state == ST_IDLE && in_valid && !in_sof) |=> !out_valid);

    // R12
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (q.bit_cnt < BW'(SUB_LEN)) && (q.sub_cnt < SW'(SUBFRAMES)) && (q.crc_cnt < CW'(R)));

endmodule

// File: tb/crc_frame_enc_test.sv
module crc_frame_enc_test;

    localparam int CLK_PERIOD = 10;
    localparam int CAPN = 256;

    typedef struct packed {
        logic [9:0]  msg;
        logic [15:0] out;
    } vec_t;

    // R=3, x^3+x^2+1, zero preset, two 5-bit subframes per frame
    localparam vec_t TBL [4] = '{
        '{msg: 10'b1001110011, out: 16'b1001101110011011},
        '{msg: 10'b0000011111, out: 16'b0000000011111110},
        '{msg: 10'b1111110000, out: 16'b1111111010000001},
        '{msg: 10'b1000000000, out: 16'b1000000100000000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sbit = 1'b0;
    logic ssof = 1'b0;
    logic [3:0] vld = '0;
    logic [3:0] rdy, ov, ob, oc;

    int total = 0;
    int bad = 0;

    logic capb [4][CAPN];
    logic capf [4][CAPN];
    int   ncap [4] = '{0, 0, 0, 0};

    logic expb [CAPN];
    logic expf [CAPN];
    int   nexp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_frame_enc #(.R(3), .POLY(4'b1101), .INIT(3'b000), .XOR_OUT(3'b000),
        .DIRECT(1'b0), .SUBFRAMES(2), .SUB_LEN(5)) uut (
        .clk(clk), .rst(rst), .in_valid(vld[0]), .in_sof(ssof), .in_bit(sbit),
        .in_ready(rdy[0]), .out_valid(ov[0]), .out_bit(ob[0]), .out_is_crc(oc[0]));

    crc_frame_enc #(.R(8), .POLY(9'h107), .INIT(8'hFF), .XOR_OUT(8'hFF),
        .DIRECT(1'b1), .SUBFRAMES(1), .SUB_LEN(23)) u_dir (
        .clk(clk), .rst(rst), .in_valid(vld[1]), .in_sof(ssof), .in_bit(sbit),
        .in_ready(rdy[1]), .out_valid(ov[1]), .out_bit(ob[1]), .out_is_crc(oc[1]));

    crc_frame_enc #(.R(16), .POLY(17'h11021), .INIT(16'hFFFF), .XOR_OUT(16'hFFFF),
        .DIRECT(1'b1), .REFLECT_IN(1'b1), .REFLECT_OUT(1'b1),
        .SUBFRAMES(1), .SUB_LEN(72)) u_ref (
        .clk(clk), .rst(rst), .in_valid(vld[2]), .in_sof(ssof), .in_bit(sbit),
        .in_ready(rdy[2]), .out_valid(ov[2]), .out_bit(ob[2]), .out_is_crc(oc[2]));

    crc_frame_enc #(.R(8), .POLY(9'h107), .INIT(8'hFF), .XOR_OUT(8'h00),
        .DIRECT(1'b0), .SUBFRAMES(3), .SUB_LEN(8)) u_ind (
        .clk(clk), .rst(rst), .in_valid(vld[3]), .in_sof(ssof), .in_bit(sbit),
        .in_ready(rdy[3]), .out_valid(ov[3]), .out_bit(ob[3]), .out_is_crc(oc[3]));

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (ov[i] && ncap[i] < CAPN) begin
                capb[i][ncap[i]] = ob[i];
                capf[i][ncap[i]] = oc[i];
                ncap[i] = ncap[i] + 1;
            end
        end
    end

    // bit-level reference: one subframe, msg sent from bit len-1 down to 0
    function automatic logic [31:0] model(int r, logic [31:0] taps, logic [31:0] init,
                                          logic [31:0] xr, bit direct, bit refin, bit refout,
                                          logic [127:0] msg, int len);
        logic [31:0] s, mask, o;
        logic b, top;
        mask = (r == 32) ? 32'hFFFF_FFFF : ((32'h1 << r) - 32'h1);
        s = init & mask;
        for (int i = 0; i < len + (direct ? 0 : r); i++) begin
            int j;
            if (i < len) begin
                j = refin ? ((i / 8) * 8 + 7 - (i % 8)) : i;
                b = msg[len-1-j];
            end else begin
                b = 1'b0;
            end
            top = s[r-1];
            if (direct) s = ((s << 1) & mask) ^ ((top ^ b) ? taps : 32'h0);
            else        s = (((s << 1) | {31'h0, b}) & mask) ^ (top ? taps : 32'h0);
        end
        o = s;
        if (refout) begin
            for (int i = 0; i < r; i++) o[i] = s[r-1-i];
        end
        return (o ^ xr) & mask;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic b, input logic f);
        expb[nexp] = b;
        expf[nexp] = f;
        nexp++;
    endtask

    task automatic push_sub(input logic [127:0] m, input int len, input logic [31:0] c, input int r);
        for (int i = 0; i < len; i++) push(m[len-1-i], 1'b0);
        for (int i = 0; i < r; i++) push(c[r-1-i], 1'b1);
    endtask

    task automatic cmp(input int sel, input int base, input string tag);
        int n, mism;
        n = ncap[sel] - base;
        chk(n == nexp, tag, "output bit count", n, nexp);
        mism = 0;
        for (int i = 0; i < nexp && i < n; i++) begin
            if (capb[sel][base+i] !== expb[i] || capf[sel][base+i] !== expf[i]) mism++;
        end
        chk(mism == 0, tag, "mismatched output bits", mism, 0);
        nexp = 0;
    endtask

    function automatic logic [31:0] capval(int sel, int start, int r);
        logic [31:0] v = '0;
        for (int i = 0; i < r; i++) v = {v[30:0], capb[sel][start+i]};
        return v;
    endfunction

    task automatic send(input int sel, input logic [127:0] msg, input int len, output int stalls);
        int i;
        stalls = 0;
        i = 0;
        while (i < len) begin
            @(negedge clk);
            sbit = msg[len-1-i];
            ssof = (i == 0);
            vld[sel] = 1'b1;
            if (rdy[sel]) i++;
            else stalls++;
        end
        @(negedge clk);
        vld[sel] = 1'b0;
        ssof = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base, st;
        logic [127:0] m;
        logic [31:0] c;

        // R11 reset state
        repeat (3) @(negedge clk);
        chk(ov == 4'b0000, "R11", "out_valid in reset", ov, 0);
        chk(rdy == 4'b1111, "R11", "in_ready in reset", rdy, 4'hF);
        rst = 1'b0;
        settle(2);

        // table walk: R1 R2 R3 R4 R5 R12
        foreach (TBL[e]) begin
            base = ncap[0];
            send(0, {118'h0, TBL[e].msg}, 10, st);
            settle(8);
            for (int p = 0; p < 16; p++) push(TBL[e].out[15-p], (p % 8) >= 5);
            cmp(0, base, "R1 R2 R4 R5 R12 table");
            chk(st == 3, "R3", "stall cycles inside frame", st, 3);
        end

        // R10: bits without sof in idle are dropped
        base = ncap[0];
        @(negedge clk);
        ssof = 1'b0;
        vld[0] = 1'b1;
        settle(6);
        vld[0] = 1'b0;
        settle(4);
        chk(ncap[0] == base, "R10", "outputs from bits without sof", ncap[0] - base, 0);

        // R11: reset in the middle of a frame
        @(negedge clk);
        vld[0] = 1'b1; ssof = 1'b1; sbit = 1'b1;
        @(negedge clk);
        ssof = 1'b0;
        settle(2);
        rst = 1'b1;
        vld[0] = 1'b0;
        @(negedge clk);
        chk(ov[0] == 1'b0, "R11", "out_valid after mid-frame reset", ov[0], 0);
        chk(rdy[0] == 1'b1, "R11", "in_ready after mid-frame reset", rdy[0], 1);
        rst = 1'b0;
        settle(2);
        base = ncap[0];
        send(0, {118'h0, TBL[1].msg}, 10, st);
        settle(8);
        for (int p = 0; p < 16; p++) push(TBL[1].out[15-p], (p % 8) >= 5);
        cmp(0, base, "R11 frame after reset");

        // R6 R9: direct division with all-ones preset and mask
        m = {105'h0, 23'b10011000000000000000011};
        base = ncap[1];
        send(1, m, 23, st);
        settle(14);
        c = model(8, 32'h07, 32'hFF, 32'hFF, 1'b1, 1'b0, 1'b0, m, 23);
        chk(c[7:0] == 8'b00011100, "R6", "reference model sanity", c, 8'h1C);
        chk(capval(1, base + 23, 8) == 32'h1C, "R6 R9", "direct checksum",
            capval(1, base + 23, 8), 8'h1C);
        push_sub(m, 23, c, 8);
        cmp(1, base, "R6 stream");

        // R7 R8: byte-reflected input, reflected checksum
        m = {56'h0, 72'h313233343536373839};
        base = ncap[2];
        send(2, m, 72, st);
        settle(22);
        chk(capval(2, base + 72, 16) == 32'h906E, "R7 R8", "reflected checksum",
            capval(2, base + 72, 16), 16'h906E);
        c = model(16, 32'h1021, 32'hFFFF, 32'hFFFF, 1'b1, 1'b1, 1'b1, m, 72);
        push_sub(m, 72, c, 16);
        cmp(2, base, "R7 stream");

        // R4 R5 R12: indirect, preset ones, three subframes
        for (int f = 0; f < 3; f++) begin
            logic [23:0] fm;
            fm = (f == 0) ? 24'hA5A5A5 : (f == 1) ? 24'h00FF3C : 24'h81_7E_00;
            base = ncap[3];
            send(3, {104'h0, fm}, 24, st);
            settle(14);
            for (int s = 0; s < 3; s++) begin
                logic [127:0] sm;
                sm = {120'h0, fm[23-8*s -: 8]};
                c = model(8, 32'h07, 32'hFF, 32'h0, 1'b0, 1'b0, 1'b0, sm, 8);
                push_sub(sm, 8, c, 8);
            end
            cmp(3, base, "R4 R5 R12 indirect");
            chk(st == 16, "R3", "stall cycles three subframes", st, 16);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule